// File: doc/BRIEF.md
# Line Sensor Scan Timing Generator

This block drives a self-scanning photodiode line sensor from a fast system clock. It builds two shift clocks that are never high together: phase A, then phase B. It also issues one scan-start pulse per integration period and a one-cycle pixel strobe after each phase B rise. The strobe carries the index of the pixel that the sensor presents on its video line. Every phase width and every gap between phases is programmed in system clock cycles.

The sensor returns an active-low end-of-scan pulse after its last pixel. The block brings this pulse into its own clock domain and reports each frame as done. If the pulse never arrives, the block raises a sticky timeout error.

The integration period is programmed as a whole number of pixel periods. If it is shorter than one readout, it is stretched to the readout length. Phase settings that break the minimum pulse widths or the maximum pixel rate are refused.

Top module: `lsens_timing_gen`

## Requirements
- R1: While reset is asserted, every output is low. After release, the first phase A high period of the block carries the first scan-start pulse.
- R2: Phase A stays high for exactly `cfg_a_width` cycles and phase B for exactly `cfg_b_width` cycles. The two phases are never high in the same cycle.
- R3: From the fall of phase A to the rise of phase B there are exactly `cfg_ab_gap` low cycles. From the fall of phase B to the rise of phase A there are exactly `cfg_ba_gap` low cycles.
- R4: Scan start rises in the same cycle as phase A and falls in the same cycle as phase B. It therefore spans one phase A, one gap and one whole phase B.
- R5: Successive scan-start rises are exactly (effective integration periods) x (A width + AB gap + B width + BA gap) cycles apart.
- R6: N is 1024 when `cfg_pix_sel` is 0 and 2048 when it is 1. In the N pixel periods that follow the start period, `pix_valid` pulses for one cycle, exactly 1 + `cfg_strobe_dly` cycles after each phase B rise. The strobe never pulses in the start period. `pix_index` counts 0 to N-1 within each frame.
- R7: A phase setting is refused when any of these holds:
  - either width is below MIN_PW (default 20);
  - either gap is 0;
  - the four terms sum to less than MIN_PER (default 50);
  - `cfg_strobe_dly` + 2 exceeds the B width.

  While a refused setting is present, `err_cfg` is high and, once the current pixel period has finished, both phases stay low. When a valid setting returns, a new frame begins with a scan-start pulse.
- R8: If `cfg_int_periods` is below N + 3, the block runs with N + 3 periods and `err_cfg` is high.
- R9: Each falling edge of `scan_end_n` gives exactly one `frame_done` pulse, 3 cycles after the edge (two synchronizer stages and an edge register). A frame whose end-of-scan never arrives gives none.
- R10: If no end-of-scan falling edge has been seen when the frame enters its pixel period N + 3 (counting the start period as 0), `err_timeout` is set. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_pix_sel | input | 1 | Pixel count select: 0 gives NPIX_LO, 1 gives NPIX_HI |
| cfg_a_width | input | CW | Phase A high time in cycles |
| cfg_ab_gap | input | CW | Low cycles from phase A fall to phase B rise |
| cfg_b_width | input | CW | Phase B high time in cycles |
| cfg_ba_gap | input | CW | Low cycles from phase B fall to phase A rise |
| cfg_strobe_dly | input | CW | Extra strobe delay after the phase B rise |
| cfg_int_periods | input | INT_W | Integration period in pixel periods |
| scan_end_n | input | 1 | Active-low end-of-scan from the sensor (asynchronous) |
| ph_a | output | 1 | Shift clock phase A |
| ph_b | output | 1 | Shift clock phase B |
| scan_start | output | 1 | Scan-start pulse to the sensor |
| pix_valid | output | 1 | One-cycle strobe: the video sample is valid |
| pix_index | output | PIX_W | Index of the pixel being strobed |
| frame_done | output | 1 | One-cycle pulse per detected end-of-scan |
| err_cfg | output | 1 | Phase setting refused or integration period stretched |
| err_timeout | output | 1 | Sticky: end-of-scan missing at its deadline |

## Verification
A wrong phase state or timer value shows on `ph_a` and `ph_b` within one pixel period, as a wrong width, a wrong gap or an overlap. A frame counter that is off by any amount moves the next scan-start rise away from its expected cycle and changes the number of strobes in the frame. Both are visible no later than the next frame boundary. A fault in the end-of-scan path changes the 3-cycle `frame_done` latency or sets `err_timeout` at the next deadline, about N + 3 pixel periods after the frame start.

// File: rtl/lsens_pkg.sv
package lsens_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_A    = 3'd1,
    PH_AB   = 3'd2,
    PH_B    = 3'd3,
    PH_BA   = 3'd4
  } ph_state_e;
endpackage

// File: rtl/lsens_cfg_check.sv
module lsens_cfg_check #(
  parameter int CW      = 8,
  parameter int INT_W   = 16,
  parameter int NPIX_LO = 1024,
  parameter int NPIX_HI = 2048,
  parameter int MIN_PW  = 20,
  parameter int MIN_PER = 50
) (
  input  logic             pix_sel,
  input  logic [CW-1:0]    a_width,
  input  logic [CW-1:0]    ab_gap,
  input  logic [CW-1:0]    b_width,
  input  logic [CW-1:0]    ba_gap,
  input  logic [CW-1:0]    strobe_dly,
  input  logic [INT_W-1:0] int_periods,
  output logic             phase_ok,
  output logic             int_short,
  output logic [INT_W-1:0] eff_int,
  output logic [INT_W-1:0] npix
);
  localparam int PER_W = CW + 2;
  localparam int DW    = CW + 1;

  logic [PER_W-1:0] period;
  logic [INT_W-1:0] rd_len;

  always_comb begin
    period   = PER_W'(a_width) + PER_W'(ab_gap) + PER_W'(b_width) + PER_W'(ba_gap);
    npix     = pix_sel ? INT_W'(NPIX_HI) : INT_W'(NPIX_LO);
    rd_len   = npix + INT_W'(3);
    phase_ok = (a_width >= CW'(MIN_PW)) && (b_width >= CW'(MIN_PW)) &&
               (ab_gap != '0) && (ba_gap != '0) &&
               (period >= PER_W'(MIN_PER)) &&
               ((DW'(strobe_dly) + DW'(2)) <= DW'(b_width));
    int_short = int_periods < rd_len;
    eff_int   = int_short ? rd_len : int_periods;
  end
endmodule

// File: rtl/lsens_phase_gen.sv
module lsens_phase_gen
  import lsens_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ok,
  input  logic [CW-1:0] a_width,
  input  logic [CW-1:0] ab_gap,
  input  logic [CW-1:0] b_width,
  input  logic [CW-1:0] ba_gap,
  input  logic [CW-1:0] strobe_dly,
  output logic          ph_a,
  output logic          ph_b,
  output logic          go_nxt,
  output logic          restart_nxt,
  output logic          hi_nxt,
  output logic          b_hit
);
  ph_state_e     st_q, st_d;
  logic [CW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] dur;

  always_comb begin
    case (st_q)
      PH_A:    dur = a_width;
      PH_AB:   dur = ab_gap;
      PH_B:    dur = b_width;
      PH_BA:   dur = ba_gap;
      default: dur = '0;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q + CW'(1);
    if (st_q == PH_IDLE) begin
      tmr_d = '0;
      if (cfg_ok) st_d = PH_A;
    end else if (tmr_q == dur - CW'(1)) begin
      tmr_d = '0;
      case (st_q)
        PH_A:    st_d = PH_AB;
        PH_AB:   st_d = PH_B;
        PH_B:    st_d = PH_BA;
        default: st_d = cfg_ok ? PH_A : PH_IDLE;
      endcase
    end
  end

  assign go_nxt      = (st_d == PH_A) && (st_q != PH_A);
  assign restart_nxt = go_nxt && (st_q == PH_IDLE);
  assign hi_nxt      = (st_d == PH_A) || (st_d == PH_AB) || (st_d == PH_B);
  assign b_hit       = (st_q == PH_B) && (tmr_q == strobe_dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      tmr_q <= '0;
      ph_a  <= 1'b0;
      ph_b  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      ph_a  <= (st_d == PH_A);
      ph_b  <= (st_d == PH_B);
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_a && ph_b));
  a_r3_gap_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_a) |-> !ph_b);
  a_r3_gap_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_b) |-> !ph_a);
  a_r7_hold_when_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && !cfg_ok) |=> (!ph_a && !ph_b));
endmodule

// File: rtl/lsens_frame_ctrl.sv
module lsens_frame_ctrl #(
  parameter int INT_W  = 16,
  parameter int PIX_W  = 11,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_nxt,
  input  logic             restart_nxt,
  input  logic             hi_nxt,
  input  logic             b_hit,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic [INT_W-1:0] eff_int,
  input  logic [INT_W-1:0] npix,
  input  logic             scan_end_n,
  output logic             scan_start,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_index,
  output logic             frame_done,
  output logic             err_timeout
);
  logic [INT_W-1:0] cnt_q, cnt_d;
  logic [PIX_W-1:0] pcnt_q;
  logic [SYNC_N:0]  end_sr;
  logic             end_fall, seen_q, frame_begin, in_pixels, strobe_d, to_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_nxt)
      cnt_d = '0;
    else if (go_nxt)
      cnt_d = (cnt_q >= eff_int - INT_W'(1)) ? '0 : cnt_q + INT_W'(1);
  end

  assign frame_begin = go_nxt && (cnt_d == '0);
  assign in_pixels   = (cnt_q != '0) && (cnt_q <= npix);
  assign strobe_d    = b_hit && in_pixels;
  assign end_fall    = end_sr[SYNC_N] && !end_sr[SYNC_N-1];
  assign to_hit      = go_nxt && !restart_nxt && (cnt_q == npix + INT_W'(2)) &&
                       !(seen_q || end_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      pcnt_q      <= '0;
      pix_index   <= '0;
      pix_valid   <= 1'b0;
      scan_start  <= 1'b0;
      end_sr      <= '1;
      seen_q      <= 1'b0;
      frame_done  <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      scan_start <= hi_nxt && (cnt_d == '0);
      pix_valid  <= strobe_d;
      end_sr     <= {end_sr[SYNC_N-1:0], scan_end_n};
      frame_done <= end_fall;
      if (frame_begin) begin
        pcnt_q <= '0;
      end else if (strobe_d) begin
        pix_index <= pcnt_q;
        pcnt_q    <= pcnt_q + PIX_W'(1);
      end
      if (frame_begin)   seen_q <= 1'b0;
      else if (end_fall) seen_q <= 1'b1;
      if (to_hit) err_timeout <= 1'b1;
    end
  end

  a_r4_start_with_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_start) |-> $rose(ph_a));
  a_r4_start_ends_with_b: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_start) |-> $fell(ph_b));
  a_r6_strobe_outside_start: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (!scan_start && !ph_a));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);
endmodule

// File: rtl/lsens_timing_gen.sv
module lsens_timing_gen #(
  parameter int CW      = 8,
  parameter int INT_W   = 16,
  parameter int NPIX_LO = 1024,
  parameter int NPIX_HI = 2048,
  parameter int PIX_W   = $clog2(NPIX_HI),
  parameter int MIN_PW  = 20,
  parameter int MIN_PER = 50,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pix_sel,
  input  logic [CW-1:0]    cfg_a_width,
  input  logic [CW-1:0]    cfg_ab_gap,
  input  logic [CW-1:0]    cfg_b_width,
  input  logic [CW-1:0]    cfg_ba_gap,
  input  logic [CW-1:0]    cfg_strobe_dly,
  input  logic [INT_W-1:0] cfg_int_periods,
  input  logic             scan_end_n,
  output logic             ph_a,
  output logic             ph_b,
  output logic             scan_start,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_index,
  output logic             frame_done,
  output logic             err_cfg,
  output logic             err_timeout
);
  logic [1:0]       rst_sync;
  logic             rst_n_i;
  logic             phase_ok, int_short;
  logic [INT_W-1:0] eff_int, npix;
  logic             go_nxt, restart_nxt, hi_nxt, b_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  lsens_cfg_check #(
    .CW(CW), .INT_W(INT_W), .NPIX_LO(NPIX_LO), .NPIX_HI(NPIX_HI),
    .MIN_PW(MIN_PW), .MIN_PER(MIN_PER)
  ) u_cfg (
    .pix_sel(cfg_pix_sel), .a_width(cfg_a_width), .ab_gap(cfg_ab_gap),
    .b_width(cfg_b_width), .ba_gap(cfg_ba_gap), .strobe_dly(cfg_strobe_dly),
    .int_periods(cfg_int_periods), .phase_ok(phase_ok), .int_short(int_short),
    .eff_int(eff_int), .npix(npix)
  );

  lsens_phase_gen #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n_i), .cfg_ok(phase_ok),
    .a_width(cfg_a_width), .ab_gap(cfg_ab_gap), .b_width(cfg_b_width),
    .ba_gap(cfg_ba_gap), .strobe_dly(cfg_strobe_dly),
    .ph_a(ph_a), .ph_b(ph_b), .go_nxt(go_nxt), .restart_nxt(restart_nxt),
    .hi_nxt(hi_nxt), .b_hit(b_hit)
  );

  lsens_frame_ctrl #(.INT_W(INT_W), .PIX_W(PIX_W), .SYNC_N(SYNC_N)) u_frame (
    .clk(clk), .rst_n(rst_n_i), .go_nxt(go_nxt), .restart_nxt(restart_nxt),
    .hi_nxt(hi_nxt), .b_hit(b_hit), .ph_a(ph_a), .ph_b(ph_b),
    .eff_int(eff_int), .npix(npix), .scan_end_n(scan_end_n),
    .scan_start(scan_start), .pix_valid(pix_valid), .pix_index(pix_index),
    .frame_done(frame_done), .err_timeout(err_timeout)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) err_cfg <= 1'b0;
    else          err_cfg <= !phase_ok || int_short;
  end
endmodule

// File: tb/sim_lsens_timing_gen.sv
module sim_lsens_timing_gen;
  localparam int CW = 8, INT_W = 16, NLO = 16, NHI = 32, PIX_W = $clog2(NHI);
  // sel, a_width, ab_gap, b_width, ba_gap, strobe_dly, int_periods
  localparam int VEC [4][7] = '{
    '{0, 20, 5, 20, 5,  0, 40},
    '{1, 25, 3, 30, 4,  7, 36},
    '{0, 22, 1, 20, 10, 18, 5},
    '{1, 30, 2, 21, 1, 19, 35}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             pix_sel;
  logic [CW-1:0]    a_w, ab_g, b_w, ba_g, s_dly;
  logic [INT_W-1:0] int_p;
  logic             end_n;
  logic             ph_a, ph_b, scan_start, pix_valid, frame_done, err_cfg, err_timeout;
  logic [PIX_W-1:0] pix_index;

  lsens_timing_gen #(
    .CW(CW), .INT_W(INT_W), .NPIX_LO(NLO), .NPIX_HI(NHI), .PIX_W(PIX_W),
    .MIN_PW(20), .MIN_PER(50), .SYNC_N(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pix_sel(pix_sel), .cfg_a_width(a_w),
    .cfg_ab_gap(ab_g), .cfg_b_width(b_w), .cfg_ba_gap(ba_g),
    .cfg_strobe_dly(s_dly), .cfg_int_periods(int_p), .scan_end_n(end_n),
    .ph_a(ph_a), .ph_b(ph_b), .scan_start(scan_start), .pix_valid(pix_valid),
    .pix_index(pix_index), .frame_done(frame_done), .err_cfg(err_cfg),
    .err_timeout(err_timeout)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  int  a_r, a_f, b_r, b_f, aw_m, bw_m, g1_m, g2_m, st_r, intv, n_start;
  int  ovl_err, align_err, idx_err, pulse_err, any_hi;
  int  pix_b, frame_pix, fd_b, frame_fd, dly_m, fd_m, b_rises, exp_n;
  bit  bf_ok, eos_en;
  logic pa, pb, pst, ppv;

  always @(negedge clk) begin
    if (!rst_n) begin
      ovl_err = 0; align_err = 0; idx_err = 0; pulse_err = 0; any_hi = 0;
      n_start = 0; pix_b = 0; fd_b = 0; frame_pix = -1; frame_fd = -1;
      b_rises = 0; bf_ok = 0; end_n = 1'b1; intv = -1; dly_m = -1; fd_m = -1;
      pa = 0; pb = 0; pst = 0; ppv = 0;
    end else begin
      if (ph_a && ph_b) ovl_err++;
      if (ph_a || ph_b) any_hi++;
      if (scan_start && !pst) begin
        if (!(ph_a && !pa)) align_err++;
        if (n_start > 0) intv = cyc - st_r;
        st_r = cyc; n_start++;
        frame_pix = pix_b; pix_b = 0; frame_fd = fd_b; fd_b = 0; b_rises = 0;
      end
      if (!scan_start && pst && !(!ph_b && pb)) align_err++;
      if (ph_a && !pa) begin a_r = cyc; if (bf_ok) g2_m = cyc - b_f; end
      if (!ph_a && pa) begin a_f = cyc; aw_m = cyc - a_r; end
      if (ph_b && !pb) begin
        b_r = cyc; g1_m = cyc - a_f; b_rises++;
        if (eos_en && b_rises == exp_n + 2) end_n = 1'b0;
      end
      if (!ph_b && pb) begin b_f = cyc; bw_m = cyc - b_r; bf_ok = 1; end_n = 1'b1; end
      if (pix_valid) begin
        if (ppv) pulse_err++;
        if (int'(pix_index) != pix_b) idx_err++;
        dly_m = cyc - b_r; pix_b++;
      end
      if (frame_done) begin fd_m = cyc - b_r; fd_b++; end
      pa = ph_a; pb = ph_b; pst = scan_start; ppv = pix_valid;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int aw, input int g1, input int bw,
                         input int g2, input int d, input int ip);
    pix_sel = s[0]; a_w = CW'(aw); ab_g = CW'(g1); b_w = CW'(bw); ba_g = CW'(g2);
    s_dly = CW'(d); int_p = INT_W'(ip); exp_n = s[0] ? NHI : NLO;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_starts(input int n);
    while (n_start < n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    eos_en = 1;
    set_cfg(0, 20, 5, 20, 5, 0, 40);
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset",
        int'({ph_a, ph_b, scan_start, pix_valid, frame_done, err_cfg, err_timeout}), 0);
    rst_n = 1'b1;
    while (!ph_a) @(negedge clk);
    chk("R1 first phase A carries scan start", int'(scan_start), 1);

    for (int v = 0; v < 4; v++) begin
      int n, per, eff;
      set_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      n   = VEC[v][0] ? NHI : NLO;
      per = VEC[v][1] + VEC[v][2] + VEC[v][3] + VEC[v][4];
      eff = (VEC[v][6] < n + 3) ? n + 3 : VEC[v][6];
      do_reset();
      wait_starts(3);
      chk("R2 phase A width", aw_m, VEC[v][1]);
      chk("R2 phase B width", bw_m, VEC[v][3]);
      chk("R2 no overlap", ovl_err, 0);
      chk("R3 A-to-B gap", g1_m, VEC[v][2]);
      chk("R3 B-to-A gap", g2_m, VEC[v][4]);
      chk("R4 start aligned to phases", align_err, 0);
      chk("R5 start interval", intv, eff * per);
      chk("R8 err_cfg for short integration", int'(err_cfg), int'(VEC[v][6] < n + 3));
      chk("R6 strobes per frame", frame_pix, n);
      chk("R6 strobe delay after phase B rise", dly_m, 1 + VEC[v][5]);
      chk("R6 pixel index sequence", idx_err + pulse_err, 0);
      chk("R9 frame_done latency", fd_m, 3);
      chk("R9 one frame_done per frame", frame_fd, 1);
      chk("R10 no timeout with end-of-scan", int'(err_timeout), 0);
    end

    // R10: end-of-scan withheld
    set_cfg(0, 20, 5, 20, 5, 0, 40);
    eos_en = 0;
    do_reset();
    wait_starts(2);
    chk("R10 timeout raised", int'(err_timeout), 1);
    chk("R9 no frame_done without end-of-scan", frame_fd, 0);
    eos_en = 1;
    wait_starts(4);
    chk("R10 timeout sticky", int'(err_timeout), 1);
    chk("R9 frame_done resumes", frame_fd, 1);

    // R7: refused phase settings
    for (int k = 0; k < 3; k++) begin
      if (k == 0)      set_cfg(0, 10, 5, 20, 20, 0, 40);
      else if (k == 1) set_cfg(0, 20, 1, 20, 1, 0, 40);
      else             set_cfg(0, 20, 5, 20, 5, 19, 40);
      do_reset();
      repeat (300) @(negedge clk);
      chk("R7 phases idle on refused setting", any_hi, 0);
      chk("R7 err_cfg on refused setting", int'(err_cfg), 1);
    end
    set_cfg(0, 20, 5, 20, 5, 0, 40);
    while (!ph_a) @(negedge clk);
    chk("R7 recovery starts a frame", int'(scan_start), 1);
    repeat (2) @(negedge clk);
    chk("R7 err_cfg clears on valid setting", int'(err_cfg), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule